// File: doc/BRIEF.md
# Bus Write-Data Error Logger

This block checks and logs write-data errors for one node on a shared memory bus. On every data beat it learns from an upstream code checker whether each of its four lanes showed a correctable (single-bit) or an uncorrectable (multi-bit) error, along with a per-lane syndrome. A node that is receiving write data records correctable and uncorrectable errors in separate sticky status bits. It captures the syndromes of the failing lanes and marks them with one lane-select bit per syndrome register. If the node is a memory node, it also latches the beat address. The data itself is still written.

A receiver that sees a data error pulses a wired, shared data-error line a fixed number of cycles later. The commander that drove the write samples that same cycle. If it finds the line asserted, it records that data it transmitted was received with errors. This holds even when its own transmit check passed. A failed transmit check while driving sets a separate bit. Software releases the frozen capture through a write-one-to-clear port. An interrupt is raised for uncorrectable errors in all cases. For correctable errors it is raised only while the correctable interrupt enable is set. Logging continues whether or not the interrupt is enabled.

The beat input is an observation of a bus that cannot be stalled. It therefore has a valid qualifier but no ready. Every beat presented with `beat_valid` high is taken in that cycle, and the block never applies back-pressure.

Top module: `werr_logger`

## Requirements
- R1: A valid beat in receiver role (`role_cmdr` low) with any bit of `lane_sbe` set sets status bit 0 (correctable error) at the next clock edge, and the bit stays set until cleared.
- R2: A valid receiver beat with any bit of `lane_mbe` set sets status bit 1 (uncorrectable error) at the next clock edge, and the bit stays set until cleared.
- R3: A valid receiver beat that carries any error drives `derr_out` high for exactly one cycle, DLY cycles after the beat (the beat is sampled at edge t, and the line is high between edges t+DLY-1 and t+DLY). Commander beats never drive it.
- R4: Status bit 2 (transmitted-data error) is set when `derr_in` is high in the cycle exactly DLY cycles after a valid commander beat. `derr_in` in any other cycle is ignored.
- R5: A valid commander beat with `tx_chk_fail` high sets status bit 3 (transmit-check error). `tx_chk_fail` on receiver beats is ignored, and so are the error flags on commander beats.
- R6: On capture, status bit 4+i is set for each failing lane i. Slice `syn_out[i*SW +: SW]` takes that lane's syndrome, and the slices of lanes that did not fail read zero.
- R7: On capture, a node with `mem_node` high latches `beat_addr` into `fail_addr`. With `mem_node` low, `fail_addr` keeps its previous value.
- R8: `irq` equals status bit 1 OR (status bit 0 AND `irq_cwde_en`).
- R9: While status bit 0 or bit 1 is set, later errors do not change `syn_out`, the lane bits or `fail_addr`. A later error of the other class still sets its own status bit.
- R10: When `csr_clr_we` is high, each status bit whose `csr_clr_mask` bit is 1 is cleared, with a set in the same cycle taking priority. Once bits 0 and 1 are both clear, capture is enabled again.
- R11: If correctable and uncorrectable lanes appear in one beat, both status bits are set. Only the uncorrectable lanes are selected and captured.
- R12: With `beat_valid` low, the lane flags, syndromes, address and `tx_chk_fail` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_node | input | 1 | Node is a memory node (address latch enabled) |
| role_cmdr | input | 1 | Node drives the current beat as commander |
| beat_valid | input | 1 | Data beat present on the bus this cycle |
| beat_addr | input | AW | Transaction address of the beat |
| lane_sbe | input | LANES | Per-lane single-bit error flag |
| lane_mbe | input | LANES | Per-lane multi-bit error flag |
| lane_syn | input | LANES*SW | Per-lane syndromes, lane i at [i*SW +: SW] |
| tx_chk_fail | input | 1 | Commander's own transmit check failed on this beat |
| derr_in | input | 1 | Sampled level of the shared data-error line |
| derr_out | output | 1 | Drive request for the shared data-error line |
| csr_clr_we | input | 1 | Write-one-to-clear strobe |
| csr_clr_mask | input | 4+LANES | Bits to clear, same positions as err_status |
| irq_cwde_en | input | 1 | Correctable-error interrupt enable |
| err_status | output | 4+LANES | {lane bits, tx-check, tx-data, uncorrectable, correctable} |
| syn_out | output | LANES*SW | Captured syndromes |
| fail_addr | output | AW | Latched failing address |
| irq | output | 1 | Error interrupt |

## Verification
The assertions take two things for granted about the inputs. First, the upstream checker raises a lane's error flags only on beats that are valid. Second, `derr_in` reflects the line in the cycle the design samples it. The bench also never issues a software clear for a bit in the same cycle as an error that sets that bit, except in one deliberate set-priority step. Each beat is one clock long, and commander and receiver beats are kept apart far enough for each error-line window to be attributed to a single beat. The early and late `derr_in` pulses are placed outside that window on purpose.

// File: rtl/werr_pkg.sv
package werr_pkg;
  // Status word bit positions; lane bits start at ST_LANE0.
  localparam int ST_CWDE  = 0;
  localparam int ST_UDE   = 1;
  localparam int ST_TDE   = 2;
  localparam int ST_TCE   = 3;
  localparam int ST_LANE0 = 4;
  localparam int ST_FIXED = 4;
endpackage

// File: rtl/werr_classify.sv
module werr_classify #(
  parameter int LANES = 4,
  parameter int SW    = 8
) (
  input  logic                  beat_valid,
  input  logic                  role_cmdr,
  input  logic [LANES-1:0]      lane_sbe,
  input  logic [LANES-1:0]      lane_mbe,
  input  logic [LANES*SW-1:0]   lane_syn,
  input  logic                  tx_chk_fail,
  output logic                  rx_corr,
  output logic                  rx_uncorr,
  output logic                  tx_fail,
  output logic                  cmd_beat,
  output logic [LANES-1:0]      lane_sel,
  output logic [LANES*SW-1:0]   syn_sel
);
  logic rx_beat;

  assign rx_beat   = beat_valid & ~role_cmdr;
  assign cmd_beat  = beat_valid & role_cmdr;
  assign rx_corr   = rx_beat & (|lane_sbe);
  assign rx_uncorr = rx_beat & (|lane_mbe);
  assign tx_fail   = cmd_beat & tx_chk_fail;

  // Uncorrectable lanes take precedence for the capture.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (rx_uncorr) lane_sel[i] = lane_mbe[i];
      else           lane_sel[i] = rx_corr & lane_sbe[i];
      syn_sel[i*SW +: SW] = lane_sel[i] ? lane_syn[i*SW +: SW] : '0;
    end
  end
endmodule

// File: rtl/werr_derr_pipe.sv
module werr_derr_pipe #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_err,
  input  logic cmd_beat,
  input  logic derr_in,
  output logic derr_out,
  output logic tde_hit
);
  logic [DLY-1:0] err_sh;
  logic [DLY-1:0] cmd_sh;

  if (DLY == 1) begin : g_one
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_sh <= '0;
        cmd_sh <= '0;
      end else begin
        err_sh <= rx_err;
        cmd_sh <= cmd_beat;
      end
    end
  end else begin : g_many
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_sh <= '0;
        cmd_sh <= '0;
      end else begin
        err_sh <= {err_sh[DLY-2:0], rx_err};
        cmd_sh <= {cmd_sh[DLY-2:0], cmd_beat};
      end
    end
  end

  assign derr_out = err_sh[DLY-1];
  assign tde_hit  = cmd_sh[DLY-1] & derr_in;
endmodule

// File: rtl/werr_status.sv
module werr_status
  import werr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int AW    = 16,
  localparam int STW  = ST_FIXED + LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_node,
  input  logic [AW-1:0]       beat_addr,
  input  logic                rx_corr,
  input  logic                rx_uncorr,
  input  logic                tx_fail,
  input  logic                tde_hit,
  input  logic [LANES-1:0]    lane_sel,
  input  logic [LANES*SW-1:0] syn_sel,
  input  logic                clr_we,
  input  logic [STW-1:0]      clr_mask,
  output logic [STW-1:0]      status,
  output logic [LANES*SW-1:0] syn_q,
  output logic [AW-1:0]       addr_q
);
  logic             cwde_q, ude_q, tde_q, tce_q;
  logic [LANES-1:0] lane_q;
  logic [STW-1:0]   wipe;
  logic             frozen, capture;

  assign wipe    = clr_we ? clr_mask : '0;
  assign frozen  = cwde_q | ude_q;
  assign capture = (rx_corr | rx_uncorr) & ~frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwde_q <= 1'b0;
      ude_q  <= 1'b0;
      tde_q  <= 1'b0;
      tce_q  <= 1'b0;
      lane_q <= '0;
      syn_q  <= '0;
      addr_q <= '0;
    end else begin
      cwde_q <= rx_corr   | (cwde_q & ~wipe[ST_CWDE]);
      ude_q  <= rx_uncorr | (ude_q  & ~wipe[ST_UDE]);
      tde_q  <= tde_hit   | (tde_q  & ~wipe[ST_TDE]);
      tce_q  <= tx_fail   | (tce_q  & ~wipe[ST_TCE]);
      if (capture) begin
        lane_q <= lane_sel;
        syn_q  <= syn_sel;
        if (mem_node) addr_q <= beat_addr;
      end else begin
        lane_q <= lane_q & ~wipe[ST_LANE0 +: LANES];
      end
    end
  end

  assign status = {lane_q, tce_q, tde_q, ude_q, cwde_q};
endmodule

// File: rtl/werr_logger.sv
module werr_logger
  import werr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int AW    = 16,
  parameter int DLY   = 2,
  localparam int STW  = ST_FIXED + LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_node,
  input  logic                role_cmdr,
  input  logic                beat_valid,
  input  logic [AW-1:0]       beat_addr,
  input  logic [LANES-1:0]    lane_sbe,
  input  logic [LANES-1:0]    lane_mbe,
  input  logic [LANES*SW-1:0] lane_syn,
  input  logic                tx_chk_fail,
  input  logic                derr_in,
  output logic                derr_out,
  input  logic                csr_clr_we,
  input  logic [STW-1:0]      csr_clr_mask,
  input  logic                irq_cwde_en,
  output logic [STW-1:0]      err_status,
  output logic [LANES*SW-1:0] syn_out,
  output logic [AW-1:0]       fail_addr,
  output logic                irq
);
  logic                rx_corr, rx_uncorr, tx_fail, cmd_beat, tde_hit;
  logic [LANES-1:0]    lane_sel;
  logic [LANES*SW-1:0] syn_sel;

  werr_classify #(.LANES(LANES), .SW(SW)) u_classify (
    .beat_valid (beat_valid),
    .role_cmdr  (role_cmdr),
    .lane_sbe   (lane_sbe),
    .lane_mbe   (lane_mbe),
    .lane_syn   (lane_syn),
    .tx_chk_fail(tx_chk_fail),
    .rx_corr    (rx_corr),
    .rx_uncorr  (rx_uncorr),
    .tx_fail    (tx_fail),
    .cmd_beat   (cmd_beat),
    .lane_sel   (lane_sel),
    .syn_sel    (syn_sel)
  );

  werr_derr_pipe #(.DLY(DLY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_err  (rx_corr | rx_uncorr),
    .cmd_beat(cmd_beat),
    .derr_in (derr_in),
    .derr_out(derr_out),
    .tde_hit (tde_hit)
  );

  werr_status #(.LANES(LANES), .SW(SW), .AW(AW)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_node (mem_node),
    .beat_addr(beat_addr),
    .rx_corr  (rx_corr),
    .rx_uncorr(rx_uncorr),
    .tx_fail  (tx_fail),
    .tde_hit  (tde_hit),
    .lane_sel (lane_sel),
    .syn_sel  (syn_sel),
    .clr_we   (csr_clr_we),
    .clr_mask (csr_clr_mask),
    .status   (err_status),
    .syn_q    (syn_out),
    .addr_q   (fail_addr)
  );

  assign irq = err_status[ST_UDE] | (err_status[ST_CWDE] & irq_cwde_en);
endmodule

// File: rtl/werr_logger_chk.sv
module werr_logger_chk
  import werr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SW    = 8,
  parameter int DLY   = 2,
  localparam int STW  = ST_FIXED + LANES
) (
  input logic                clk,
  input logic                rst_n,
  input logic                role_cmdr,
  input logic                beat_valid,
  input logic [LANES-1:0]    lane_sbe,
  input logic [LANES-1:0]    lane_mbe,
  input logic                tx_chk_fail,
  input logic                csr_clr_we,
  input logic [STW-1:0]      csr_clr_mask,
  input logic                irq_cwde_en,
  input logic [STW-1:0]      err_status,
  input logic [LANES*SW-1:0] syn_out,
  input logic                derr_out,
  input logic                irq
);
  logic       rx_any;
  logic [DLY:0] ref_sh;
  logic       locked;

  assign rx_any = beat_valid & ~role_cmdr & ((|lane_sbe) | (|lane_mbe));
  assign locked = err_status[ST_CWDE] | err_status[ST_UDE];

  always_ff @(posedge clk) begin
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[DLY-1:0], rx_any};
  end

  a_r1_corr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !role_cmdr && |lane_sbe) |=> err_status[ST_CWDE]);

  a_r2_uncorr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !role_cmdr && |lane_mbe) |=> err_status[ST_UDE]);

  a_r3_line_timing: assert property (@(posedge clk) disable iff (!rst_n)
    derr_out == ref_sh[DLY-1]);

  a_r5_tx_check: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && role_cmdr && tx_chk_fail) |=> err_status[ST_TCE]);

  a_r8_uncorr_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_status[ST_UDE] |-> irq);

  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_cwde_en && !err_status[ST_UDE]) |-> !irq);

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && locked) |-> $stable(syn_out));

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_clr_we && csr_clr_mask[ST_TCE] && !(beat_valid && role_cmdr && tx_chk_fail))
      |=> !err_status[ST_TCE]);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid && !csr_clr_we)
      |=> ($stable(err_status[ST_TCE:ST_CWDE] & 4'b1011) && $stable(syn_out)));
endmodule

bind werr_logger werr_logger_chk #(.LANES(LANES), .SW(SW), .DLY(DLY)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .role_cmdr   (role_cmdr),
  .beat_valid  (beat_valid),
  .lane_sbe    (lane_sbe),
  .lane_mbe    (lane_mbe),
  .tx_chk_fail (tx_chk_fail),
  .csr_clr_we  (csr_clr_we),
  .csr_clr_mask(csr_clr_mask),
  .irq_cwde_en (irq_cwde_en),
  .err_status  (err_status),
  .syn_out     (syn_out),
  .derr_out    (derr_out),
  .irq         (irq)
);

// File: tb/tb_werr_logger.sv
module tb_werr_logger;
  localparam int LANES = 4;
  localparam int SW    = 8;
  localparam int AW    = 16;
  localparam int DLY   = 2;
  localparam int STW   = 4 + LANES;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                mem_node = 1'b1, role_cmdr = 1'b0, beat_valid = 1'b0;
  logic [AW-1:0]       beat_addr = '0;
  logic [LANES-1:0]    lane_sbe = '0, lane_mbe = '0;
  logic [LANES*SW-1:0] lane_syn = '0;
  logic                tx_chk_fail = 1'b0, derr_in = 1'b0, derr_out;
  logic                csr_clr_we = 1'b0;
  logic [STW-1:0]      csr_clr_mask = '0;
  logic                irq_cwde_en = 1'b1;
  logic [STW-1:0]      err_status;
  logic [LANES*SW-1:0] syn_out;
  logic [AW-1:0]       fail_addr;
  logic                irq;

  always #2 clk = ~clk;  // 250 MHz

  werr_logger #(.LANES(LANES), .SW(SW), .AW(AW), .DLY(DLY)) dut (.*);

  typedef struct packed {
    logic [STW-1:0]      st;
    logic [LANES*SW-1:0] syn;
    logic [AW-1:0]       addr;
    logic                irq;
    logic                derr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  mon_ev;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  // Bench reference state, derived from the requirements.
  logic             m_cwde = 0, m_ude = 0, m_tde = 0, m_tce = 0;
  logic [LANES-1:0] m_lane = '0;
  logic [LANES*SW-1:0] m_syn = '0;
  logic [AW-1:0]    m_addr = '0;
  logic [DLY-1:0]   h_err = '0, h_cmd = '0;

  task automatic step(input logic v, input logic cmd, input logic [AW-1:0] a,
                      input logic [LANES-1:0] s, input logic [LANES-1:0] m,
                      input logic [LANES*SW-1:0] sy, input logic txf, input logic din,
                      input logic cwe, input logic [STW-1:0] cm, input string tag);
    logic rx, ec, eu, hit, cap;
    logic [LANES-1:0] sel;
    exp_t e;
    beat_valid = v; role_cmdr = cmd; beat_addr = a; lane_sbe = s; lane_mbe = m;
    lane_syn = sy; tx_chk_fail = txf; derr_in = din; csr_clr_we = cwe; csr_clr_mask = cm;
    rx  = v && !cmd;
    ec  = rx && (|s);
    eu  = rx && (|m);
    hit = h_cmd[DLY-1] && din;
    cap = (ec || eu) && !(m_cwde || m_ude);
    sel = eu ? m : (ec ? s : '0);
    if (cwe) begin
      m_cwde &= ~cm[0]; m_ude &= ~cm[1]; m_tde &= ~cm[2]; m_tce &= ~cm[3];
      if (!cap) m_lane &= ~cm[7:4];
    end
    m_cwde |= ec; m_ude |= eu; m_tde |= hit; m_tce |= (v && cmd && txf);
    if (cap) begin
      m_lane = sel;
      for (int i = 0; i < LANES; i++)
        m_syn[i*SW +: SW] = sel[i] ? sy[i*SW +: SW] : '0;
      if (mem_node) m_addr = a;
    end
    h_err = {h_err[DLY-2:0], ec || eu};
    h_cmd = {h_cmd[DLY-2:0], v && cmd};
    e.st   = {m_lane, m_tce, m_tde, m_ude, m_cwde};
    e.syn  = m_syn;
    e.addr = m_addr;
    e.irq  = m_ude || (m_cwde && irq_cwde_en);
    e.derr = h_err[DLY-1];
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> mon_ev;
    #1;
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, '0, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic clr(input logic [STW-1:0] cm, input string tag);
    step(0, 0, '0, '0, '0, '0, 0, 0, 1, cm, tag);
  endtask

  // Monitor: pops one expectation per step and compares.
  initial begin
    forever begin
      @(mon_ev);
      begin
        exp_t e;
        string t;
        bit bad;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        bad = 0;
        n_vec++;
        if (err_status !== e.st) begin
          bad = 1; $display("FAIL %s status act=%h exp=%h", t, err_status, e.st);
        end
        if (syn_out !== e.syn) begin
          bad = 1; $display("FAIL %s syndrome act=%h exp=%h", t, syn_out, e.syn);
        end
        if (fail_addr !== e.addr) begin
          bad = 1; $display("FAIL %s addr act=%h exp=%h", t, fail_addr, e.addr);
        end
        if (irq !== e.irq) begin
          bad = 1; $display("FAIL %s irq act=%b exp=%b", t, irq, e.irq);
        end
        if (derr_out !== e.derr) begin
          bad = 1; $display("FAIL %s derr_out act=%b exp=%b", t, derr_out, e.derr);
        end
        if (bad) n_bad++;
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    idle("R12 reset state");
    // R1 R6 R7 R8: receiver correctable error on lane 1 of a memory node
    step(1, 0, 16'h1234, 4'b0010, 4'b0000, 32'h0000_5A00, 0, 0, 0, '0, "R1 R6 R7 R8 corr capture");
    idle("R3 line pulse");
    idle("R3 line single cycle");
    // R9: second error while frozen leaves capture alone
    step(1, 0, 16'h4444, 4'b0100, 4'b0000, 32'h0033_0000, 0, 0, 0, '0, "R9 frozen capture");
    idle("R3 second pulse");
    clr(8'hF1, "R10 clear corr and lanes");
    // R11 R2 R8: mixed beat with interrupt enable off
    irq_cwde_en = 1'b0;
    step(1, 0, 16'h00AA, 4'b1000, 4'b0001, 32'hC300_0077, 0, 0, 0, '0, "R11 R2 R8 mixed beat");
    idle("R8 uncorr irq with enable off");
    clr(8'hFF, "R10 clear all");
    step(1, 0, 16'h0BBB, 4'b0100, 4'b0000, 32'h0011_0000, 0, 0, 0, '0, "R8 corr masked");
    irq_cwde_en = 1'b1;
    idle("R8 corr enabled");
    clr(8'hFF, "R10 clear before non-memory");
    mem_node = 1'b0;
    step(1, 0, 16'h7777, 4'b0001, 4'b0000, 32'h0000_0099, 0, 0, 0, '0, "R7 non-memory keeps addr");
    clr(8'hFF, "R10 clear before commander");
    mem_node = 1'b1;
    // R5 R3: commander beat, flags ignored, no line pulse
    step(1, 1, 16'h2222, 4'b0001, 4'b0010, 32'hFFFF_FFFF, 1, 0, 0, '0, "R5 R3 commander beat");
    step(0, 0, '0, '0, '0, '0, 0, 1, 0, '0, "R4 early line ignored");
    step(0, 0, '0, '0, '0, '0, 0, 1, 0, '0, "R4 window sets tx-data bit");
    step(0, 0, '0, '0, '0, '0, 0, 1, 0, '0, "R4 late line ignored");
    clr(8'hFF, "R10 clear tx bits");
    step(1, 0, 16'h3333, 4'b0000, 4'b0000, 32'h1234_5678, 1, 0, 0, '0, "R5 receiver tx check ignored");
    step(0, 0, 16'h5555, 4'b1111, 4'b1111, 32'hAAAA_AAAA, 1, 0, 0, '0, "R12 invalid beat ignored");
    step(1, 0, 16'h6666, 4'b0010, 4'b0000, 32'h0000_4200, 0, 0, 1, 8'h01, "R10 set wins over clear");
    idle("R3 tail");
    idle("R9 tail");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule